// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches a recovered bipolar line stream and decides when the line has lost its signal. The stream comes in as two rail inputs, one for positive marks and one for negative marks, together with a bit-clock enable. A bit period with no pulse on either rail is a zero. A long run of zeros declares loss of signal. An external loss indication from a line interface device also declares it, through a two-stage synchronizer. Clearing uses hysteresis. An internally declared loss is dropped only after a full 32-bit window that contains no run of four zeros.

The block drives a level LOS output and reports the same state through a small register port. Every change of the LOS state, entering or leaving, sets a clear-on-read change flag. That flag raises an interrupt output when its enable bit is set. A mode bit turns the internal zero-run detector off, so that only the external input can declare loss.

Top module: `los_detector`

## Requirements
- R1: A bit is counted only in a cycle where `bit_en` is high. It is a zero when both `rx_pos` and `rx_neg` are low, and a pulse on either rail or on both rails makes it a one.
- R2: With internal detection enabled, `los_o` rises at the clock edge that samples the 32nd consecutive zero. A run of 31 zeros followed by a one does not declare loss.
- R3: `ext_los` high declares loss whatever the internal detector's state. `los_o` rises at the third rising edge after `ext_los` goes high: two synchronizer flops and then the output register.
- R4: Bit 5 of the mode register at address 0x00 enables internal detection and resets to 1. While it is 0, zero runs never declare loss, and an internally held loss is dropped one edge after the write takes effect.
- R5: Bit 4 of the status register at address 0x11 reads the current LOS state. Read data appears on `rd_data` after the edge that samples `rd_en`. Writes to 0x11 have no effect.
- R6: Bit 1 of the change register at address 0x14 is set at the same edge at which `los_o` changes in either direction. A read of 0x14 clears it. If a change and a read of 0x14 fall in the same cycle, the read returns the old value and the bit stays set.
- R7: An internally held loss clears at the edge that samples the 32nd bit of a window. The window begins with the first one after declaration. Runs of up to three zeros inside the window are allowed.
- R8: A run of four zeros inside a clearing window abandons that window. A fresh window begins with the next one.
- R9: When `ext_los` returns low, `los_o` falls at the third rising edge after that, but only if the internal detector is not also holding loss. Otherwise `los_o` stays high.
- R10: `irq_o` is high exactly while the change bit is set and bit 1 of the enable register at address 0x12 is set. That enable bit resets to 0.
- R11: After reset, `los_o` is 1, the change bit is 0, `irq_o` is 0 and all run and window counts are zero.
- R12: Cycles with `bit_en` low neither advance nor break a zero run or a clearing window, whatever the rails carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable, one line bit per high cycle |
| rx_pos | input | 1 | Positive rail mark |
| rx_neg | input | 1 | Negative rail mark |
| ext_los | input | 1 | Asynchronous external loss indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Registered read data |
| los_o | output | 1 | Loss-of-signal level |
| irq_o | output | 1 | Enabled change-of-state interrupt |

## Verification
A line bit decides `los_o` at the edge that samples it, so the bench drives each bit on a falling edge and checks `los_o` on the next falling edge. That gives zero extra cycles for declaring or clearing from the rails. Changes on `ext_los` reach `los_o` at the third rising edge, so the bench checks that the output has not moved after two edges and has moved after three. Read data and clear-on-read take effect at the edge after the strobe, so each read is checked one cycle after it is issued. The change flag is set at the same edge as `los_o`, which lets the bench place a read and a clearing bit in one cycle to test which one wins.

// File: rtl/los_pkg.sv
package los_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] ADR_MODE = 8'h00;
  localparam logic [REG_AW-1:0] ADR_STAT = 8'h11;
  localparam logic [REG_AW-1:0] ADR_IEN  = 8'h12;
  localparam logic [REG_AW-1:0] ADR_CHG  = 8'h14;

  localparam int BIT_INT_EN = 5;
  localparam int BIT_LOS    = 4;
  localparam int BIT_CHG    = 1;
  localparam int BIT_IEN    = 1;
endpackage

// File: rtl/los_sync.sv
module los_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/los_zero_run.sv
module los_zero_run #(
  parameter int DECL_RUN = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bit_en,
  input  logic                          is_zero,
  output logic                          hit,
  output logic [$clog2(DECL_RUN+1)-1:0] run_cnt
);
  localparam int CW = $clog2(DECL_RUN + 1);
  localparam logic [CW-1:0] LAST = CW'(DECL_RUN - 1);
  localparam logic [CW-1:0] TOP  = CW'(DECL_RUN);

  // this bit completes (or extends) a run long enough to declare
  assign hit = bit_en && is_zero && (run_cnt >= LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (bit_en) begin
      if (!is_zero)           run_cnt <= '0;
      else if (run_cnt != TOP) run_cnt <= run_cnt + 1'b1;
    end
  end

  a_r2_run_saturates: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= TOP);
  a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(run_cnt));
endmodule

// File: rtl/los_clear_window.sv
module los_clear_window #(
  parameter int WIN_LEN   = 32,
  parameter int RUN_LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic bit_en,
  input  logic is_zero,
  output logic done
);
  localparam int WW = $clog2(WIN_LEN + 1);
  localparam int RW = $clog2(RUN_LIMIT + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);
  localparam logic [WW-1:0] WIN_TOP  = WW'(WIN_LEN);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LIMIT - 1);

  logic          armed;
  logic [WW-1:0] win_cnt;
  logic [RW-1:0] zrun;
  logic          breaks;

  assign breaks = is_zero && (zrun == RUN_LAST);
  assign done   = active && armed && bit_en && !breaks && (win_cnt == WIN_LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      armed   <= 1'b0;
      win_cnt <= '0;
      zrun    <= '0;
    end else if (bit_en) begin
      if (!armed) begin
        if (!is_zero) begin
          armed   <= 1'b1;
          win_cnt <= WW'(1);
          zrun    <= '0;
        end
      end else if (breaks) begin
        armed   <= 1'b0;
        win_cnt <= '0;
        zrun    <= '0;
      end else begin
        if (win_cnt != WIN_TOP) win_cnt <= win_cnt + 1'b1;
        zrun <= is_zero ? zrun + 1'b1 : '0;
      end
    end
  end

  a_r7_window_bounded: assert property (@(posedge clk) disable iff (rst)
    win_cnt <= WIN_TOP);
  a_r8_run_restarts: assert property (@(posedge clk) disable iff (rst)
    (active && armed && bit_en && breaks) |=> !armed);
  a_r12_window_idle: assert property (@(posedge clk) disable iff (rst)
    (active && !bit_en) |=> ($stable(win_cnt) || !active));
endmodule

// File: rtl/los_regs.sv
module los_regs
  import los_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic              los,
  input  logic              chg,
  output logic [REG_DW-1:0] rd_data,
  output logic              int_en,
  output logic              chg_sts,
  output logic              irq_o
);
  logic              ien;
  logic              rd_chg;
  logic [REG_DW-1:0] rd_mux;
  logic [REG_DW-1:0] unused_wr_bits;

  assign unused_wr_bits = wr_data;
  assign rd_chg = rd_en && (addr == ADR_CHG);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_en <= 1'b1;
      ien    <= 1'b0;
    end else if (wr_en) begin
      if (addr == ADR_MODE) int_en <= wr_data[BIT_INT_EN];
      if (addr == ADR_IEN)  ien    <= wr_data[BIT_IEN];
    end
  end

  // set has priority over clear-on-read
  always_ff @(posedge clk) begin
    if (rst)         chg_sts <= 1'b0;
    else if (chg)    chg_sts <= 1'b1;
    else if (rd_chg) chg_sts <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_MODE: rd_mux[BIT_INT_EN] = int_en;
      ADR_STAT: rd_mux[BIT_LOS]    = los;
      ADR_IEN:  rd_mux[BIT_IEN]    = ien;
      ADR_CHG:  rd_mux[BIT_CHG]    = chg_sts;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign irq_o = chg_sts && ien;

  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    chg |=> chg_sts);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_chg && !chg) |=> !chg_sts);
endmodule

// File: rtl/los_detector.sv
module los_detector
  import los_pkg::*;
#(
  parameter int DECL_RUN    = 32,
  parameter int WIN_LEN     = 32,
  parameter int RUN_LIMIT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              rx_pos,
  input  logic              rx_neg,
  input  logic              ext_los,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wr_data,
  output logic [REG_DW-1:0] rd_data,
  output logic              los_o,
  output logic              irq_o
);
  localparam int CW = $clog2(DECL_RUN + 1);

  logic          is_zero;
  logic          ext_s;
  logic          hit;
  logic          done;
  logic [CW-1:0] run_cnt;
  logic          int_en;
  logic          chg_sts;
  logic          int_los_q;
  logic          int_los_d;
  logic          los_d;
  logic          chg;

  assign is_zero = !(rx_pos || rx_neg);

  los_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_los),
    .q   (ext_s)
  );

  los_zero_run #(.DECL_RUN(DECL_RUN)) u_run (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .is_zero (is_zero),
    .hit     (hit),
    .run_cnt (run_cnt)
  );

  los_clear_window #(.WIN_LEN(WIN_LEN), .RUN_LIMIT(RUN_LIMIT)) u_win (
    .clk     (clk),
    .rst     (rst),
    .active  (int_los_q),
    .bit_en  (bit_en),
    .is_zero (is_zero),
    .done    (done)
  );

  always_comb begin
    if (!int_en)   int_los_d = 1'b0;
    else if (hit)  int_los_d = 1'b1;
    else if (done) int_los_d = 1'b0;
    else           int_los_d = int_los_q;
  end

  assign los_d = int_los_d || ext_s;
  assign chg   = (los_d != los_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_los_q <= 1'b1;
      los_o     <= 1'b1;
    end else begin
      int_los_q <= int_los_d;
      los_o     <= los_d;
    end
  end

  los_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .los     (los_o),
    .chg     (chg),
    .rd_data (rd_data),
    .int_en  (int_en),
    .chg_sts (chg_sts),
    .irq_o   (irq_o)
  );

  a_r2_declare: assert property (@(posedge clk) disable iff (rst)
    (int_en && hit) |=> los_o);
  a_r3_external: assert property (@(posedge clk) disable iff (rst)
    ext_s |=> los_o);
  a_r4_internal_off: assert property (@(posedge clk) disable iff (rst)
    (!int_en && !ext_s) |=> !los_o);
  a_r9_internal_holds: assert property (@(posedge clk) disable iff (rst)
    (int_en && int_los_q && !done) |=> los_o);
  a_r6_change_flag: assert property (@(posedge clk) disable iff (rst)
    (los_o != $past(los_o)) |-> chg_sts);
  a_r11_run_clear_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (run_cnt == '0));
endmodule

// File: tb/los_detector_bench.sv
`timescale 1ns/1ps
module los_detector_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       rx_pos = 1'b0;
  logic       rx_neg = 1'b0;
  logic       ext_los = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       los_o;
  logic       irq_o;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  los_detector u_los_detector (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .ext_los(ext_los), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .los_o(los_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one line bit; rails: 0 none, 1 pos, 2 neg, 3 both
  task automatic send_bit(input int rails);
    bit_en = 1'b1;
    rx_pos = rails[0];
    rx_neg = rails[1];
    @(negedge clk);
    bit_en = 1'b0;
    rx_pos = 1'b0;
    rx_neg = 1'b0;
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(0);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1 + (i % 3));
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
    rd_en = 1'b1;
    addr  = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    wr_en   = 1'b1;
    addr    = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check("R11 los after reset", los_o, 1);
    check("R11 irq after reset", irq_o, 0);
    reg_read(8'h14, rv); check("R11 change bit after reset", rv[1], 0);
    reg_read(8'h11, rv); check("R5 status shows los", rv, 8'h10);
    reg_read(8'h00, rv); check("R4 mode reset value", rv, 8'h20);
    reg_read(8'h12, rv); check("R10 enable reset value", rv, 8'h00);
    reg_write(8'h11, 8'h00);
    reg_read(8'h11, rv); check("R5 write to status ignored", rv, 8'h10);

    // R7 first window after reset; leading zeros do not count
    send_zeros(5);
    send_bit(1);
    send_ones(30);
    check("R7 held after 31 window bits", los_o, 1);
    send_bit(2);
    check("R7 cleared at 32nd window bit", los_o, 0);
    reg_read(8'h14, rv); check("R6 change set on clear", rv[1], 1);
    reg_read(8'h14, rv); check("R6 cleared by read", rv[1], 0);

    // R2 / R1 sweep of run lengths; the closing one uses each rail pattern
    for (int len = 28; len <= 36; len++) begin
      send_zeros(len);
      check($sformatf("R2 run of %0d zeros", len), los_o, (len >= 32) ? 1 : 0);
      send_bit(1 + (len % 3));
      check($sformatf("R1 one after run %0d", len), los_o, (len >= 32) ? 1 : 0);
      if (len >= 32) begin
        send_ones(31);
        check($sformatf("R7 clear after run %0d", len), los_o, 0);
      end
    end
    reg_read(8'h14, rv);

    // R1 a negative-only or double mark breaks the run
    send_zeros(20); send_bit(2); send_zeros(20); send_bit(3); send_zeros(31);
    check("R1 marks broke the runs", los_o, 0);
    send_bit(0);
    check("R2 declared at 32nd zero", los_o, 1);

    // R8 four zeros abandon the window
    send_bit(1); send_ones(10); send_zeros(4);
    check("R8 held after abandoned window", los_o, 1);
    send_bit(1); send_ones(30);
    check("R8 new window not yet full", los_o, 1);
    send_bit(2);
    check("R8 new window clears", los_o, 0);

    // R7 three zeros inside a window are tolerated
    send_zeros(32);
    check("R2 declared again", los_o, 1);
    send_bit(1); send_ones(10); send_zeros(3); send_ones(17);
    check("R7 three-zero window not full", los_o, 1);
    send_bit(1);
    check("R7 three-zero window clears", los_o, 0);

    // R12 idle cycles do not count or break
    send_zeros(20);
    rx_pos = 1'b1;
    repeat (50) @(negedge clk);
    rx_pos = 1'b0;
    send_zeros(11);
    check("R12 idle marks did not break run", los_o, 0);
    send_bit(0);
    check("R12 run continued across idle", los_o, 1);
    send_bit(1); send_ones(30);
    repeat (10) @(negedge clk);
    send_bit(3);
    check("R12 idle zeros did not restart window", los_o, 0);
    reg_read(8'h14, rv);

    // R4 internal detection off
    send_zeros(32);
    check("R2 declared before disable", los_o, 1);
    reg_write(8'h00, 8'h00);
    @(negedge clk);
    check("R4 internal loss dropped", los_o, 0);
    send_zeros(40);
    check("R4 zeros ignored when disabled", los_o, 0);
    reg_read(8'h00, rv); check("R4 mode readback", rv, 8'h00);

    // R3 / R9 external path latency
    ext_los = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 not yet after two edges", los_o, 0);
    @(negedge clk);
    check("R3 declared at third edge", los_o, 1);
    ext_los = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 still high after two edges", los_o, 1);
    @(negedge clk);
    check("R9 released at third edge", los_o, 0);

    send_bit(1);
    reg_write(8'h00, 8'h20);
    reg_read(8'h14, rv);

    // R9 internal criterion keeps loss after external release
    send_zeros(32);
    ext_los = 1'b1;
    repeat (5) @(negedge clk);
    ext_los = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 internal holds after external release", los_o, 1);
    send_bit(1); send_ones(31);
    check("R7 cleared after external episode", los_o, 0);

    // R10 interrupt enable
    reg_read(8'h14, rv);
    reg_write(8'h12, 8'h02);
    check("R10 irq low with flag clear", irq_o, 0);
    send_zeros(32);
    check("R10 irq on change", irq_o, 1);
    reg_read(8'h14, rv);
    check("R10 irq low after read", irq_o, 0);

    // R6 change and read in the same cycle
    send_bit(1); send_ones(30);
    bit_en = 1'b1; rx_pos = 1'b1; rd_en = 1'b1; addr = 8'h14;
    @(negedge clk);
    bit_en = 1'b0; rx_pos = 1'b0; rd_en = 1'b0;
    check("R6 read returns old value", rd_data[1], 0);
    check("R7 clear in same cycle as read", los_o, 0);
    check("R10 irq after simultaneous set", irq_o, 1);
    reg_read(8'h14, rv); check("R6 set won over read", rv[1], 1);
    reg_read(8'h11, rv); check("R5 status shows clear", rv, 8'h00);

    finish_run();
  end
endmodule